// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

The block sits between a 32-bit register bus and an array of 128 fuse words of 32 bits each. In this design the array is held in registers. Software can sense-read any fuse word into a result register. It can program a word, which ORs new one-bits into that word, but only while a 16-bit unlock key sits in the control word. It can also refresh a bank of shadow registers from the array in a single command; those shadows are then visible on the bus.

Every sense and program operation holds a busy flag for a length of time built from a timing register. An error flag records any request that was refused: a start while an operation is running, or a program attempt without the key. A single sequencer with four states carries out the operations:

- IDLE: waiting. IDLE goes to SENSE on an accepted read start, to BLOW on an accepted program, and to RELOAD on an accepted reload.
- SENSE: busy. When the timer expires it goes back to IDLE and captures the addressed word into the result register.
- BLOW: busy. When the timer expires it goes back to IDLE, ORs the data into the word and clears the key.
- RELOAD: busy. It copies one word per cycle and goes back to IDLE after the last word.

Bus map, as byte offsets:

| Offset | Register |
|---|---|
| 0x000 | control word |
| 0x004 | set alias of the control word |
| 0x008 | clear alias of the control word |
| 0x010 | timing |
| 0x020 | program data (write only) |
| 0x030 | read start (write only) |
| 0x040 | read result |
| 0x400 + 16*i | shadow word i |

Control word bit fields:

| Bits | Field |
|---|---|
| 31:16 | key |
| 10 | reload |
| 9 | error |
| 8 | busy |
| 6:0 | word address |

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the control word reads 0, the timing register reads 0x00062020, the read result reads 0, and every shadow word reads 0.
- R2: A bus write to the control word loads its address field (bits 6:0) and its key field (bits 31:16). A write to the set alias ORs wdata into those two fields. A write to the clear alias clears the bits of those two fields that are set in wdata. Bits 15:11 and bit 7 always read 0.
- R3: Writing 1 to bit 0 at 0x030 while idle starts a sense read. Busy (bit 8) is then high for exactly read-strobe + 2*(relax+1) cycles. After that, the result register at 0x040 holds the addressed fuse word.
- R4: Writing 0x020 while idle with key 0x3E77 present starts a program. Busy is then high for exactly program-strobe + 2*(relax+1) cycles. After that, the addressed fuse word equals its old value ORed with the written data.
- R5: A write to 0x020 while idle with any other key sets the error flag (bit 9). It does not start busy and leaves the fuse array unchanged.
- R6: A read start, program write or reload request that arrives while busy is high sets the error flag. It starts nothing, leaves the fuse array unchanged, and leaves the key unchanged.
- R7: When a program completes, the key field reads 0. The address field is kept.
- R8: Writing bit 10 through the control word or the set alias while idle starts a reload. Bit 10 and busy are then both high for exactly 128 cycles and clear together. Afterwards every shadow word equals its fuse word.
- R9: Programming never changes a shadow word. Only reset and reload write the shadows.
- R10: Writing 1 in bit 9 to the clear alias clears the error flag.
- R11: The timing register holds program strobe in bits 11:0, relax in bits 15:12 and read strobe in bits 21:16. Bits 31:22 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| bus_wr | input | 1 | write strobe, one cycle per write |
| bus_addr | input | 12 | byte address for writes and reads |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for bus_addr, combinational |

## Verification
The assertions assume that each bus write lasts exactly one cycle and carries a stable address. They also assume that software writes the key before it writes the data register. The bench drives each write for one cycle between falling edges and changes the address only at falling edges. It therefore places refused requests deliberately: a program write during a running sense, and a data write with a wrong key while idle. Busy lengths are measured by polling the control word once per cycle and comparing the count against the value computed from the timing fields.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

    localparam logic [11:0] OFS_CTRL   = 12'h000;
    localparam logic [11:0] OFS_SET    = 12'h004;
    localparam logic [11:0] OFS_CLR    = 12'h008;
    localparam logic [11:0] OFS_TIMING = 12'h010;
    localparam logic [11:0] OFS_DATA   = 12'h020;
    localparam logic [11:0] OFS_RDCTL  = 12'h030;
    localparam logic [11:0] OFS_RESULT = 12'h040;
    localparam int          SHADOW_BASE = 'h400;
    localparam int          SHADOW_STEP_LOG = 4;

    localparam int BIT_BUSY   = 8;
    localparam int BIT_ERR    = 9;
    localparam int BIT_RELOAD = 10;
    localparam int KEY_LSB    = 16;

    localparam int T_SP_W = 12;
    localparam int T_RL_W = 4;
    localparam int T_SR_W = 6;
    localparam int T_RL_LSB = 12;
    localparam int T_SR_LSB = 16;
    localparam int TMR_W = T_SP_W + T_RL_W + 2;

    localparam logic [T_SP_W-1:0] T_SP_RST = 12'h020;
    localparam logic [T_RL_W-1:0] T_RL_RST = 4'h2;
    localparam logic [T_SR_W-1:0] T_SR_RST = 6'h06;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SENSE,
        ST_BLOW,
        ST_RELOAD
    } otp_state_t;
endpackage

// File: rtl/otp_op_timer.sv
module otp_op_timer #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= len;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == CW'(1));
endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store #(
    parameter int NWORDS = 128,
    parameter int DW     = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      prog_en,
    input  logic [$clog2(NWORDS)-1:0] prog_idx,
    input  logic [DW-1:0]             prog_data,
    input  logic [$clog2(NWORDS)-1:0] rd_idx,
    output logic [DW-1:0]             rd_data
);
    localparam int IDXW = $clog2(NWORDS);

    logic [DW-1:0]     cells [NWORDS];
    logic [NWORDS-1:0] hit;

    for (genvar w = 0; w < NWORDS; w++) begin : g_hit
        assign hit[w] = prog_en && (prog_idx == IDXW'(w));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) cells[i] <= '0;
        end else begin
            for (int i = 0; i < NWORDS; i++) begin
                if (hit[i]) cells[i] <= cells[i] | prog_data;
            end
        end
    end

    assign rd_data = cells[rd_idx];
endmodule

// File: rtl/otp_shadow_bank.sv
module otp_shadow_bank #(
    parameter int NWORDS = 128,
    parameter int DW     = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_en,
    input  logic [$clog2(NWORDS)-1:0] ld_idx,
    input  logic [DW-1:0]             ld_data,
    input  logic [$clog2(NWORDS)-1:0] rd_idx,
    output logic [DW-1:0]             rd_data
);
    localparam int IDXW = $clog2(NWORDS);

    logic [DW-1:0]     regs [NWORDS];
    logic [NWORDS-1:0] sel;

    for (genvar w = 0; w < NWORDS; w++) begin : g_sel
        assign sel[w] = ld_en && (ld_idx == IDXW'(w));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) regs[i] <= '0;
        end else begin
            for (int i = 0; i < NWORDS; i++) begin
                if (sel[i]) regs[i] <= ld_data;
            end
        end
    end

    assign rd_data = regs[rd_idx];
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_pkg::*;
#(
    parameter int NWORDS = 128,
    parameter int AW     = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata
);
    localparam int DW   = 32;
    localparam int IDXW = $clog2(NWORDS);
    localparam int SH_END = SHADOW_BASE + (NWORDS << SHADOW_STEP_LOG);

    otp_state_t state, state_nx;

    logic [IDXW-1:0]   ctrl_addr;
    logic [15:0]       ctrl_key;
    logic              ctrl_err;
    logic [T_SP_W-1:0] t_sp;
    logic [T_RL_W-1:0] t_rl;
    logic [T_SR_W-1:0] t_sr;
    logic [DW-1:0]     rd_result;
    logic [IDXW-1:0]   op_idx;
    logic [DW-1:0]     op_data;
    logic [IDXW-1:0]   rl_idx;

    logic wr_ctrl, wr_set, wr_clr, wr_timing, wr_data, wr_rdctl;
    logic req_sense, req_blow, req_reload;
    logic acc_sense, acc_blow, acc_reload, fault;
    logic op_busy, reload_flag, sense_done, blow_done, reload_last;
    logic tmr_start, tmr_done;
    logic [TMR_W-1:0] tmr_len, relax_pair;

    logic [IDXW-1:0] fuse_rd_idx;
    logic [DW-1:0]   fuse_rd_data;
    logic            sh_hit;
    logic [AW-1:0]   sh_off;
    logic [IDXW-1:0] sh_idx;
    logic [DW-1:0]   sh_rd_data;
    logic [31:0]     ctrl_word;

    // bus write decode
    always_comb begin
        wr_ctrl   = bus_wr && (bus_addr == AW'(OFS_CTRL));
        wr_set    = bus_wr && (bus_addr == AW'(OFS_SET));
        wr_clr    = bus_wr && (bus_addr == AW'(OFS_CLR));
        wr_timing = bus_wr && (bus_addr == AW'(OFS_TIMING));
        wr_data   = bus_wr && (bus_addr == AW'(OFS_DATA));
        wr_rdctl  = bus_wr && (bus_addr == AW'(OFS_RDCTL));
        req_sense  = wr_rdctl && bus_wdata[0];
        req_blow   = wr_data;
        req_reload = (wr_ctrl || wr_set) && bus_wdata[BIT_RELOAD];
    end

    // request arbitration against the sequencer state
    always_comb begin
        acc_sense  = req_sense && !op_busy;
        acc_blow   = req_blow && !op_busy && (ctrl_key == UNLOCK_KEY);
        acc_reload = req_reload && !op_busy;
        fault = (op_busy && (req_sense || req_blow || req_reload)) ||
                (req_blow && !op_busy && (ctrl_key != UNLOCK_KEY));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (acc_blow)        state_nx = ST_BLOW;
                else if (acc_sense)  state_nx = ST_SENSE;
                else if (acc_reload) state_nx = ST_RELOAD;
            end
            ST_SENSE:  if (tmr_done)    state_nx = ST_IDLE;
            ST_BLOW:   if (tmr_done)    state_nx = ST_IDLE;
            ST_RELOAD: if (reload_last) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        relax_pair  = (TMR_W'(t_rl) + TMR_W'(1)) << 1;
        op_busy     = 1'b0;
        reload_flag = 1'b0;
        sense_done  = 1'b0;
        blow_done   = 1'b0;
        reload_last = 1'b0;
        tmr_start   = 1'b0;
        tmr_len     = '0;
        unique case (state)
            ST_IDLE: begin
                tmr_start = acc_blow || acc_sense;
                tmr_len   = acc_blow ? (TMR_W'(t_sp) + relax_pair)
                                     : (TMR_W'(t_sr) + relax_pair);
            end
            ST_SENSE: begin
                op_busy    = 1'b1;
                sense_done = tmr_done;
            end
            ST_BLOW: begin
                op_busy   = 1'b1;
                blow_done = tmr_done;
            end
            ST_RELOAD: begin
                op_busy     = 1'b1;
                reload_flag = 1'b1;
                reload_last = (rl_idx == IDXW'(NWORDS - 1));
            end
            default: ;
        endcase
    end

    // control word fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_addr <= '0;
            ctrl_key  <= '0;
            ctrl_err  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_addr <= bus_wdata[IDXW-1:0];
                ctrl_key  <= bus_wdata[KEY_LSB +: 16];
            end else if (wr_set) begin
                ctrl_addr <= ctrl_addr | bus_wdata[IDXW-1:0];
                ctrl_key  <= ctrl_key | bus_wdata[KEY_LSB +: 16];
            end else if (wr_clr) begin
                ctrl_addr <= ctrl_addr & ~bus_wdata[IDXW-1:0];
                ctrl_key  <= ctrl_key & ~bus_wdata[KEY_LSB +: 16];
            end
            if (blow_done) ctrl_key <= '0;
            if (fault)                            ctrl_err <= 1'b1;
            else if (wr_clr && bus_wdata[BIT_ERR]) ctrl_err <= 1'b0;
        end
    end

    // timing register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_sp <= T_SP_RST;
            t_rl <= T_RL_RST;
            t_sr <= T_SR_RST;
        end else if (wr_timing) begin
            t_sp <= bus_wdata[T_SP_W-1:0];
            t_rl <= bus_wdata[T_RL_LSB +: T_RL_W];
            t_sr <= bus_wdata[T_SR_LSB +: T_SR_W];
        end
    end

    // operation operands, reload walk and read result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_idx    <= '0;
            op_data   <= '0;
            rl_idx    <= '0;
            rd_result <= '0;
        end else begin
            if (acc_sense || acc_blow) op_idx <= ctrl_addr;
            if (acc_blow)              op_data <= bus_wdata;
            if (state == ST_IDLE && acc_reload) rl_idx <= '0;
            else if (reload_flag)               rl_idx <= rl_idx + 1'b1;
            if (sense_done) rd_result <= fuse_rd_data;
        end
    end

    otp_op_timer #(.CW(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .len   (tmr_len),
        .done  (tmr_done)
    );

    assign fuse_rd_idx = reload_flag ? rl_idx : op_idx;

    otp_fuse_store #(.NWORDS(NWORDS), .DW(DW)) u_fuses (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (blow_done),
        .prog_idx  (op_idx),
        .prog_data (op_data),
        .rd_idx    (fuse_rd_idx),
        .rd_data   (fuse_rd_data)
    );

    otp_shadow_bank #(.NWORDS(NWORDS), .DW(DW)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (reload_flag),
        .ld_idx  (rl_idx),
        .ld_data (fuse_rd_data),
        .rd_idx  (sh_idx),
        .rd_data (sh_rd_data)
    );

    // bus read path
    always_comb begin
        sh_off = bus_addr - AW'(SHADOW_BASE);
        sh_idx = sh_off[SHADOW_STEP_LOG +: IDXW];
        sh_hit = (int'(bus_addr) >= SHADOW_BASE) && (int'(bus_addr) < SH_END) &&
                 (bus_addr[SHADOW_STEP_LOG-1:0] == '0);
        ctrl_word = '0;
        ctrl_word[KEY_LSB +: 16] = ctrl_key;
        ctrl_word[BIT_RELOAD]    = reload_flag;
        ctrl_word[BIT_ERR]       = ctrl_err;
        ctrl_word[BIT_BUSY]      = op_busy;
        ctrl_word[IDXW-1:0]      = ctrl_addr;
        bus_rdata = '0;
        if (sh_hit) begin
            bus_rdata = sh_rd_data;
        end else if (bus_addr == AW'(OFS_CTRL) || bus_addr == AW'(OFS_SET) ||
                     bus_addr == AW'(OFS_CLR)) begin
            bus_rdata = ctrl_word;
        end else if (bus_addr == AW'(OFS_TIMING)) begin
            bus_rdata[T_SP_W-1:0]          = t_sp;
            bus_rdata[T_RL_LSB +: T_RL_W]  = t_rl;
            bus_rdata[T_SR_LSB +: T_SR_W]  = t_sr;
        end else if (bus_addr == AW'(OFS_RESULT)) begin
            bus_rdata = rd_result;
        end
    end
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk
    import otp_pkg::*;
#(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          busy,
    input logic          err,
    input logic          reload,
    input logic [15:0]   key
);
    logic in_prog;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_prog <= 1'b0;
        else if (bus_wr && bus_addr == AW'(OFS_DATA) && !busy && key == UNLOCK_KEY)
            in_prog <= 1'b1;
        else if (!busy) in_prog <= 1'b0;
    end

    // R3, R4: busy only rises after a bus write
    a_r3_busy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr));

    // R5: a wrong key flags error and starts nothing
    a_r5_bad_key_error: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFS_DATA) && !busy && key != UNLOCK_KEY)
        |=> (err && !busy));

    // R6: a read start during busy flags error
    a_r6_busy_start_error: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFS_RDCTL) && bus_wdata[0] && busy) |=> err);

    // R7: key is gone once a program has finished
    a_r7_key_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog && !busy) |-> (key == 16'h0000));

    // R8: reload flag never shows without busy
    a_r8_reload_busy: assert property (@(posedge clk) disable iff (!rst_n)
        reload |-> busy);

    // R10: clear alias removes the error flag
    a_r10_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFS_CLR) && bus_wdata[BIT_ERR] && !busy) |=> !err);
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (op_busy),
    .err       (ctrl_err),
    .reload    (reload_flag),
    .key       (ctrl_key)
);

// File: tb/otp_fuse_ctrl_tb.sv
module otp_fuse_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q [$];
    logic [11:0] addr_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    otp_fuse_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    // monitor: compares queued expectations against the read port
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            logic [11:0] a;
            string t;
            e = exp_q.pop_front();
            a = addr_q.pop_front();
            t = tag_q.pop_front();
            check(bus_rdata === e, $sformatf("%s @%h", t, a), bus_rdata, e);
        end
    end

    task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string t);
        @(negedge clk); #1;
        bus_addr = a;
        exp_q.push_back(e);
        addr_q.push_back(a);
        tag_q.push_back(t);
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    // call straight after wr: counts cycles with busy set
    task automatic busy_len(output int n, output logic [31:0] first);
        n = 0;
        bus_addr = '0;
        #0;
        first = bus_rdata;
        while (bus_rdata[8] && n < 5000) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic wait_idle();
        int n;
        logic [31:0] f;
        busy_len(n, f);
    endtask

    task automatic sense(input logic [6:0] idx, input logic [31:0] e, input string t);
        wr(12'h008, 32'h0000_007F);
        wr(12'h004, {25'h0, idx});
        wr(12'h030, 32'h1);
        wait_idle();
        expect_rd(12'h040, e, t);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [31:0] f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_rd(12'h000, 32'h0, "R1 ctrl");
        expect_rd(12'h010, 32'h0006_2020, "R1 timing");
        expect_rd(12'h040, 32'h0, "R1 result");
        expect_rd(12'h400, 32'h0, "R1 shadow0");
        expect_rd(12'hBF0, 32'h0, "R1 shadow127");

        // R11 timing fields
        wr(12'h010, 32'hFFFF_FFFF);
        expect_rd(12'h010, 32'h003F_FFFF, "R11 mask");
        wr(12'h010, 32'h0003_1005);
        expect_rd(12'h010, 32'h0003_1005, "R11 value");

        // R2 control aliases
        wr(12'h000, 32'h3E77_0005);
        expect_rd(12'h000, 32'h3E77_0005, "R2 direct");
        wr(12'h004, 32'h0000_0002);
        expect_rd(12'h000, 32'h3E77_0007, "R2 set");
        wr(12'h008, 32'h0000_0004);
        expect_rd(12'h000, 32'h3E77_0003, "R2 clear");
        wr(12'h008, 32'hFFFF_0000);
        expect_rd(12'h000, 32'h0000_0003, "R2 clear key");

        // R4 program word 3, busy 5+2*2
        wr(12'h000, 32'h3E77_0003);
        wr(12'h020, 32'h0000_00F0);
        busy_len(n, f);
        check(n == 9, "R4 busy len", n, 9);
        // R7 key cleared, address kept
        expect_rd(12'h000, 32'h0000_0003, "R7 key cleared");
        // R3 sense with busy 3+2*2
        wr(12'h030, 32'h1);
        busy_len(n, f);
        check(n == 7, "R3 busy len", n, 7);
        expect_rd(12'h040, 32'h0000_00F0, "R3 result");

        // R4 second program ORs
        wr(12'h000, 32'h3E77_0003);
        wr(12'h020, 32'h0F00_000F);
        wait_idle();
        sense(7'd3, 32'h0F00_00FF, "R4 OR result");
        // R9 shadow untouched
        expect_rd(12'h430, 32'h0, "R9 shadow3 before reload");

        // R5 wrong key
        wr(12'h000, 32'h1234_0003);
        wr(12'h020, 32'hFFFF_FFFF);
        busy_len(n, f);
        check(n == 0, "R5 no busy", n, 0);
        expect_rd(12'h000, 32'h1234_0203, "R5 error set");
        // R10 clear error
        wr(12'h008, 32'h0000_0200);
        expect_rd(12'h000, 32'h1234_0003, "R10 error cleared");
        wr(12'h008, 32'hFFFF_0000);
        sense(7'd3, 32'h0F00_00FF, "R5 fuse unchanged");

        // R6 program attempt during a sense
        wr(12'h000, 32'h3E77_0003);
        wr(12'h030, 32'h1);
        wr(12'h020, 32'hFFFF_0000);
        wait_idle();
        expect_rd(12'h000, 32'h3E77_0203, "R6 error, key kept");
        expect_rd(12'h040, 32'h0F00_00FF, "R6 sense result");
        wr(12'h008, 32'hFFFF_0200);
        sense(7'd3, 32'h0F00_00FF, "R6 fuse unchanged");

        // R8 reload
        wr(12'h000, 32'h3E77_007F);
        wr(12'h020, 32'hA5A5_A5A5);
        wait_idle();
        wr(12'h004, 32'h0000_0400);
        busy_len(n, f);
        check(n == 128, "R8 reload len", n, 128);
        check(f == 32'h0000_057F, "R8 reload flag", f, 32'h0000_057F);
        expect_rd(12'h000, 32'h0000_007F, "R8 flag cleared");
        expect_rd(12'h430, 32'h0F00_00FF, "R8 shadow3");
        expect_rd(12'hBF0, 32'hA5A5_A5A5, "R8 shadow127");
        expect_rd(12'h400, 32'h0, "R8 shadow0");

        // R9 program after reload leaves shadow alone
        wr(12'h000, 32'h3E77_0000);
        wr(12'h020, 32'h0000_0001);
        wait_idle();
        expect_rd(12'h400, 32'h0, "R9 shadow0 after program");
        sense(7'd0, 32'h0000_0001, "R9 fuse0 programmed");

        // R6 reload request while busy
        wr(12'h030, 32'h1);
        wr(12'h004, 32'h0000_0400);
        wait_idle();
        expect_rd(12'h000, 32'h0000_0200, "R6 reload refused");

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule